// File: doc/BRIEF.md
# Three-Cycle Block Transfer Sequencer

This block moves a block of 12-bit words between main memory and a 256-word local sector buffer. Each word costs three memory cycles. The first cycle reads the transfer count from a fixed memory location and writes it back plus one. The second reads the current-address location, which is the count location with bit 0 forced to one, and writes it back plus one. The third moves one data word at that freshly incremented address. Software primes the count location with minus n to move n words, and primes the address location with one less than the first target.

A start request in the idle state does four things: it latches the direction, latches the count location, loads the combined disk word address, and launches the sequence. Each word takes nine clock cycles. A word ends in one of three ways:
- The engine loops to the next word.
- The count has run out. The engine raises a one-cycle done pulse and goes idle.
- The local buffer index has wrapped. The engine raises a one-cycle end-of-buffer pulse and waits idle for a continue request.

Top module: `brk3_engine`

## Requirements
- R1: After reset the engine is idle, and the following are all zero: `done_o`, `eob_o`, `mem_we_o`, `mem_addr_o`, `da_o` and the buffer index.
- R2: `start_i` sampled high while idle latches `dir_i`, `wc_loc_i` and `da_init_i`, and enters the count-read cycle on the next edge. A `start_i` while busy has no effect on the transfer.
- R3: Each word takes nine cycles, and the memory address follows this pattern: the count location for three cycles, then count location OR 1 for three cycles, then the new current address for three cycles.
- R4: In the second cycle of a word, the count location is written with its read value plus one. The word count therefore reads zero after n words.
- R5: In the fifth cycle of a word, the address location is written with its read value plus one. That new value is the data address for the word.
- R6: With `dir_i`=1 (disk-write direction), the memory word at the data address is stored into the buffer at the current index, and no memory write happens in the transfer cycle.
- R7: With `dir_i`=0 (disk-read direction), the buffer word at the current index is written to the data address.
- R8: `mem_we_o` is high only in the count-write cycle, the address-write cycle, and the transfer cycle of a disk-read word. This gives 2 strobes per word when writing to disk and 3 when reading from disk. The address is held stable through each finish cycle.
- R9: A word whose count reads back as all ones (octal 7777) is the last. After its finish cycle, `done_o` pulses for exactly one cycle and the engine goes idle. This happens 9n+1 cycles after start when no wrap intervenes.
- R10: The 8-bit buffer index advances after every word. If it wraps to zero on a word that is not the last, `eob_o` pulses for one cycle and the engine goes idle. If the wrap falls on the last word, only `done_o` pulses.
- R11: With an end-of-buffer pending, `cont_i` in idle resumes at the count-read cycle, keeping the direction and an index of zero. Without a pending end-of-buffer, `cont_i` is ignored.
- R12: The 20-bit disk word address `da_o` increments by one after every word and wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| cont_i | input | 1 | Continue after end-of-buffer |
| dir_i | input | 1 | 1: memory to buffer, 0: buffer to memory |
| wc_loc_i | input | 12 | Memory location of the word count |
| da_init_i | input | 20 | Disk word address loaded on start |
| mem_rdata_i | input | 12 | Memory read data, valid one cycle after the address |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| eob_o | output | 1 | One-cycle end-of-buffer pulse |
| da_o | output | 20 | Current disk word address |

## Verification
The bench runs a series of directed transfers:
- A full 256-word write to the buffer, in which the index wraps on exactly the last word. This separates done-over-wrap priority from a spurious end-of-buffer.
- A full 256-word read back, which shows every buffer slot holds what was stored.
- A 300-word transfer that must stop at the wrap and resume on continue. A stray start is issued during it and must be ignored.
- A single-word transfer at a different count location with a disk address of all ones. This exposes the three-cycle address pattern, the immediate last-word case and address wraparound.

Random transfers of mixed direction, length and buffer offset then compare memory, count and address locations, strobe counts and latency against a bench model of the buffer.

// File: rtl/brk3_pkg.sv
package brk3_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_WC,
    S_WR_WC,
    S_FIN_WC,
    S_RD_CA,
    S_WR_CA,
    S_FIN_CA,
    S_SET_ADR,
    S_XFER,
    S_FINISH
  } brk_state_e;

  function automatic logic in_cnt_phase(brk_state_e s);
    return (s == S_RD_WC) || (s == S_WR_WC) || (s == S_FIN_WC);
  endfunction

  function automatic logic in_ca_phase(brk_state_e s);
    return (s == S_RD_CA) || (s == S_WR_CA) || (s == S_FIN_CA);
  endfunction

  function automatic logic in_data_phase(brk_state_e s);
    return (s == S_SET_ADR) || (s == S_XFER) || (s == S_FINISH);
  endfunction

endpackage

// File: rtl/brk3_seq.sv
module brk3_seq
  import brk3_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              dir_i,
  input  logic [WORD_W-1:0] wc_rd_i,
  input  logic              idx_last_i,
  output brk_state_e        st_o,
  output logic              dir_q_o,
  output logic              load_o,
  output logic              done_o,
  output logic              eob_o
);

  function automatic logic count_is_last(logic [WORD_W-1:0] w);
    return &w;
  endfunction

  brk_state_e st_q, nxt;
  logic       done_flag_q;
  logic       eob_pend_q;
  logic       resume;
  logic       wrap_stop;

  assign load_o    = (st_q == S_IDLE) && start_i;
  assign resume    = (st_q == S_IDLE) && !start_i && cont_i && eob_pend_q;
  assign wrap_stop = (st_q == S_FINISH) && !done_flag_q && idx_last_i;
  assign st_o      = st_q;

  always_comb begin
    nxt = st_q;
    case (st_q)
      S_IDLE:    if (load_o || resume) nxt = S_RD_WC;
      S_RD_WC:   nxt = S_WR_WC;
      S_WR_WC:   nxt = S_FIN_WC;
      S_FIN_WC:  nxt = S_RD_CA;
      S_RD_CA:   nxt = S_WR_CA;
      S_WR_CA:   nxt = S_FIN_CA;
      S_FIN_CA:  nxt = S_SET_ADR;
      S_SET_ADR: nxt = S_XFER;
      S_XFER:    nxt = S_FINISH;
      S_FINISH:  nxt = (done_flag_q || idx_last_i) ? S_IDLE : S_RD_WC;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      done_flag_q <= 1'b0;
      eob_pend_q  <= 1'b0;
      dir_q_o     <= 1'b0;
      done_o      <= 1'b0;
      eob_o       <= 1'b0;
    end else begin
      st_q   <= nxt;
      done_o <= (st_q == S_FINISH) && done_flag_q;
      eob_o  <= wrap_stop;
      if (load_o) begin
        dir_q_o    <= dir_i;
        eob_pend_q <= 1'b0;
      end else if (resume) begin
        eob_pend_q <= 1'b0;
      end else if (wrap_stop) begin
        eob_pend_q <= 1'b1;
      end
      if (st_q == S_RD_WC) done_flag_q <= 1'b0;
      else if (st_q == S_WR_WC && count_is_last(wc_rd_i)) done_flag_q <= 1'b1;
    end
  end

endmodule

// File: rtl/brk3_buf.sv
module brk3_buf #(
  parameter int WORD_W = 12,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_i,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rword_o,
  output logic [BUF_AW-1:0] idx_o,
  output logic              idx_last_o
);

  localparam int DEPTH = 1 << BUF_AW;

  function automatic logic [BUF_AW-1:0] idx_step(logic [BUF_AW-1:0] i);
    return i + 1'b1;
  endfunction

  logic [WORD_W-1:0] store_q [DEPTH];
  logic [BUF_AW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (store_i) store_q[idx_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (adv_i) idx_q <= idx_step(idx_q);
  end

  assign rword_o    = store_q[idx_q];
  assign idx_o      = idx_q;
  assign idx_last_o = &idx_q;

endmodule

// File: rtl/brk3_addr.sv
module brk3_addr
  import brk3_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int EXT_W  = 8,
  localparam int DA_W  = EXT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brk_state_e        st_i,
  input  logic              dir_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] wc_loc_i,
  input  logic [DA_W-1:0]   da_init_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0] buf_word_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [DA_W-1:0]   da_o
);

  function automatic logic [WORD_W-1:0] word_step(logic [WORD_W-1:0] w);
    return w + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] ca_loc(logic [WORD_W-1:0] loc);
    return loc | WORD_W'(1);
  endfunction

  function automatic logic [DA_W-1:0] da_step(logic [DA_W-1:0] d);
    return d + 1'b1;
  endfunction

  logic [WORD_W-1:0] wc_loc_q;
  logic [WORD_W-1:0] ca_q;
  logic [DA_W-1:0]   da_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_loc_q <= '0;
      ca_q     <= '0;
      da_q     <= '0;
    end else begin
      if (load_i) begin
        wc_loc_q <= wc_loc_i;
        da_q     <= da_init_i;
      end else if (st_i == S_FINISH) begin
        da_q <= da_step(da_q);
      end
      if (st_i == S_WR_CA) ca_q <= word_step(rdata_i);
    end
  end

  always_comb begin
    if (in_cnt_phase(st_i))       mem_addr_o = wc_loc_q;
    else if (in_ca_phase(st_i))   mem_addr_o = ca_loc(wc_loc_q);
    else if (in_data_phase(st_i)) mem_addr_o = ca_q;
    else                          mem_addr_o = '0;
  end

  always_comb begin
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    case (st_i)
      S_WR_WC, S_WR_CA: begin
        mem_wdata_o = word_step(rdata_i);
        mem_we_o    = 1'b1;
      end
      S_XFER: if (!dir_i) begin
        mem_wdata_o = buf_word_i;
        mem_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign da_o = da_q;

endmodule

// File: rtl/brk3_engine.sv
module brk3_engine
  import brk3_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int BUF_AW = 8,
  parameter int EXT_W  = 8,
  localparam int DA_W  = EXT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              dir_i,
  input  logic [WORD_W-1:0] wc_loc_i,
  input  logic [DA_W-1:0]   da_init_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              done_o,
  output logic              eob_o,
  output logic [DA_W-1:0]   da_o
);

  brk_state_e        st;
  logic              dir_q;
  logic              load;
  logic              idx_last;
  logic [BUF_AW-1:0] idx;
  logic [WORD_W-1:0] buf_word;
  logic              store_ev;
  logic              fin_ev;

  assign store_ev = (st == S_XFER) && dir_q;
  assign fin_ev   = (st == S_FINISH);

  brk3_seq #(.WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cont_i     (cont_i),
    .dir_i      (dir_i),
    .wc_rd_i    (mem_rdata_i),
    .idx_last_i (idx_last),
    .st_o       (st),
    .dir_q_o    (dir_q),
    .load_o     (load),
    .done_o     (done_o),
    .eob_o      (eob_o)
  );

  brk3_buf #(.WORD_W(WORD_W), .BUF_AW(BUF_AW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_i    (store_ev),
    .adv_i      (fin_ev),
    .wdata_i    (mem_rdata_i),
    .rword_o    (buf_word),
    .idx_o      (idx),
    .idx_last_o (idx_last)
  );

  brk3_addr #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_i        (st),
    .dir_i       (dir_q),
    .load_i      (load),
    .wc_loc_i    (wc_loc_i),
    .da_init_i   (da_init_i),
    .rdata_i     (mem_rdata_i),
    .buf_word_i  (buf_word),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .da_o        (da_o)
  );

endmodule

// File: rtl/brk3_engine_chk.sv
module brk3_engine_chk
  import brk3_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int BUF_AW = 8,
  parameter int DA_W   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input brk_state_e        st,
  input logic              start_i,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              eob_o,
  input logic [BUF_AW-1:0] idx,
  input logic [DA_W-1:0]   da_o
);

  AST_WE_IN_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (st == S_WR_WC || st == S_WR_CA || st == S_XFER)); // R8

  AST_ADDR_HELD_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN_WC || st == S_FIN_CA || st == S_FINISH) |-> $stable(mem_addr_o)); // R8

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i) |=> (st == S_RD_WC)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (st == S_IDLE)); // R9

  AST_EOB_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eob_o |-> (idx == '0 && st == S_IDLE)); // R10

  AST_DONE_EOB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && eob_o)); // R10

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FINISH) |=> (idx == BUF_AW'($past(idx) + 1'b1))); // R10

  AST_DA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FINISH) |=> (da_o == DA_W'($past(da_o) + 1'b1))); // R12

endmodule

bind brk3_engine brk3_engine_chk #(
  .WORD_W(WORD_W), .BUF_AW(BUF_AW), .DA_W(DA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .start_i    (start_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .eob_o      (eob_o),
  .idx        (idx),
  .da_o       (da_o)
);

// File: tb/brk3_engine_tb.sv
module brk3_engine_tb;

  localparam int CLK_P = 10;
  localparam logic [11:0] LOC0 = 12'o7750;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cont = 1'b0, dir = 1'b0;
  logic [11:0] wc_loc = LOC0;
  logic [19:0] da_init = '0;
  logic [11:0] rdata;
  logic [11:0] mem_addr, mem_wdata;
  logic        mem_we, done, eob;
  logic [19:0] da;

  logic [11:0] mem [4096];
  logic        tb_we = 1'b0;
  logic [11:0] tb_a = '0, tb_d = '0;

  logic [11:0] bmodel [256];
  int idx_m = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  brk3_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont), .dir_i(dir),
    .wc_loc_i(wc_loc), .da_init_i(da_init), .mem_rdata_i(rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .done_o(done), .eob_o(eob), .da_o(da)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    rdata <= mem[mem_addr];
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic poke(logic [11:0] a, logic [11:0] d);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic int exp_wraps(int i0, int n);
    int w = 0;
    for (int k = 1; k < n; k++) if (((i0 + k) % 256) == 0) w++;
    return w;
  endfunction

  function automatic logic [11:0] exp_addr(int c, logic [11:0] loc, logic [11:0] a);
    if (c <= 3) return loc;
    if (c <= 6) return loc | 12'd1;
    return a;
  endfunction

  task automatic run_xfer(bit d, int n, logic [11:0] a, logic [19:0] da0,
                          logic [11:0] loc, bit stray_start);
    int cyc = 1, dones = 0, eobs = 0, wes = 0, done_cyc = 0, addr_bad = 0, data_bad = 0;
    int wraps = exp_wraps(idx_m, n);
    logic [11:0] bad_act = '0, bad_exp = '0;
    poke(loc, 12'(-n));
    poke(loc | 12'd1, a - 12'd1);
    if (d) for (int i = 0; i < n; i++) poke(a + 12'(i), 12'($urandom));
    start = 1'b1; dir = d; wc_loc = loc; da_init = da0;
    @(negedge clk);
    start = 1'b0; dir = ~d; wc_loc = 12'o0;
    while (dones == 0 && cyc < 20000) begin
      if (cyc <= 9 && mem_addr != exp_addr(cyc, loc, a)) addr_bad++;
      if (mem_we) wes++;
      if (eob) begin eobs++; cont = 1'b1; end
      if (done) begin dones++; done_cyc = cyc; end
      if (stray_start && cyc == 20) start = 1'b1;
      @(negedge clk);
      cont = 1'b0; start = 1'b0;
      if (dones == 0) cyc++;
    end
    chk(!done, "R9", "done pulse width", done, 0);
    chk(addr_bad == 0, "R3", "address pattern mismatches", addr_bad, 0);
    chk(done_cyc == 9 * n + 1 + wraps, "R9", "done latency", done_cyc, 9 * n + 1 + wraps);
    chk(eobs == wraps, "R10", "end-of-buffer pulses", eobs, wraps);
    chk(mem[loc] == 12'd0, "R4", "final word count", mem[loc], 0);
    chk(mem[loc | 12'd1] == a - 12'd1 + 12'(n), "R5", "final current address",
        mem[loc | 12'd1], a - 12'd1 + 12'(n));
    chk(da == da0 + 20'(n), "R12", "disk word address", da, da0 + 20'(n));
    chk(wes == n * (d ? 2 : 3), "R8", "write strobes", wes, n * (d ? 2 : 3));
    for (int i = 0; i < n; i++) begin
      int bi = (idx_m + i) % 256;
      if (d) bmodel[bi] = mem[a + 12'(i)];
      else if (mem[a + 12'(i)] !== bmodel[bi]) begin
        if (data_bad == 0) begin bad_act = mem[a + 12'(i)]; bad_exp = bmodel[bi]; end
        data_bad++;
      end
    end
    if (!d) chk(data_bad == 0, "R7", "buffer word read back (stored per R6)", bad_act, bad_exp);
    idx_m = (idx_m + n) % 256;
  endtask

  initial begin
    int bad;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(done == 0 && eob == 0, "R1", "pulses after reset", {done, eob}, 0);
    chk(mem_we == 0, "R1", "write strobe after reset", mem_we, 0);
    chk(mem_addr == 0, "R1", "address after reset", mem_addr, 0);
    chk(da == 0, "R1", "disk address after reset", da, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: index wraps on the last word, only done expected
    run_xfer(1'b1, 256, 12'o1000, 20'h00FF0, LOC0, 1'b0);
    // R6/R7 full read back
    run_xfer(1'b0, 256, 12'o2000, 20'h12345, LOC0, 1'b0);
    // R11 wrap mid-transfer with resume; R2 stray start while busy
    run_xfer(1'b1, 300, 12'o3000, 20'h00010, LOC0, 1'b1);

    // R11: continue without pending end-of-buffer is ignored
    cont = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mem_addr != 0 || mem_we) bad++;
    end
    cont = 1'b0;
    chk(bad == 0, "R11", "idle activity after stray continue", bad, 0);

    // R9 single word at another count location, R12 address wrap
    run_xfer(1'b0, 1, 12'o0400, 20'hFFFFF, 12'o0100, 1'b0);

    for (int t = 0; t < 10; t++) begin
      bit d = 1'($urandom);
      int n = 1 + int'($urandom % 60);
      logic [11:0] a = 12'o0200 + 12'($urandom % 12'o5000);
      run_xfer(d, n, a, 20'($urandom), LOC0, 1'b0);
    end
    // read back whatever is left in the buffer model: R7
    run_xfer(1'b0, 256, 12'o6000, 20'h0, LOC0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule